// File: doc/BRIEF.md
# Shared Interrupt Line Router

The router collects eight level-sensitive shared interrupt lines (PIRQ A to H) and one system control interrupt (SCI) and turns them into request levels for a sixteen-input legacy PIC and for a row of APIC global system interrupt (GSI) inputs. Each shared line has its own routing byte that either connects it to one PIC input or leaves it off the PIC. The APIC side does not depend on those bytes: shared line n always reaches GSI 16+n, so no two shared lines ever meet on one APIC input.

The SCI is held in a level register and can be steered to IRQ 9, 10 or 11, which sit on both the PIC and the APIC, or to GSI 20 or 21, which exist only on the APIC. Every output is the OR of all sources routed to it. Software sets the routing bytes and the SCI select through a byte-wide write port with a combinational read-back. A separate query port reports, for one chosen shared line, where that line is delivered.

Top module: `irq_router_top`

## Requirements
- R1: After reset every routing byte reads 0x80, the SCI select reads 0 (IRQ 9), the stored SCI level is low, and with all shared lines low every PIC and GSI output is low.
- R2: Register address 0..7 holds the routing byte of shared line 0..7. All eight bits are stored and read back. Address 8 holds the SCI select in bits 2:0, and bits 7:3 read as zero.
- R3: In a routing byte, bits 3:0 name the PIC input and bit 7 clear connects the line. A PIC output is high when any connected shared line naming it is high, so several lines can share one input.
- R4: A shared line whose routing byte has bit 7 set drives no PIC output, whatever its bits 3:0 hold.
- R5: GSI output 16+n equals shared line n (ORed with the SCI when the SCI is steered to that GSI), independent of the routing bytes. GSI 0..15 carry no shared line.
- R6: The SCI select encodes 0 = IRQ 9, 1 = IRQ 10, 2 = IRQ 11, 4 = GSI 20, 5 = GSI 21. The values 3, 6 and 7 leave the SCI connected to nothing.
- R7: A high stored SCI level raises the selected GSI output. It also raises the PIC output of the same number only when that number is below 16.
- R8: The SCI input is captured on each rising clock edge and reaches the outputs one cycle later. Shared lines reach the outputs combinationally in the same cycle.
- R9: For the shared line named on the query port, a line with bit 7 set reports the APIC path (PIC flag 0, IRQ 16+n). A connected line reports the PIC path (PIC flag 1, IRQ equal to bits 3:0).
- R10: Writes to addresses 9 to 15 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pirq_i | input | 8 | Shared interrupt lines A..H, active high |
| sci_i | input | 1 | System control interrupt level |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Read-back of the register at cfg_addr_i |
| qry_pirq_i | input | 3 | Shared line to query |
| qry_pic_o | output | 1 | 1 when the queried line is delivered to the PIC |
| qry_irq_o | output | 5 | IRQ or GSI number the queried line reaches |
| pic_irq_o | output | 16 | PIC request levels |
| gsi_o | output | 24 | APIC GSI request levels |

## Verification
Every cycle, the checker confirms that a high shared line always shows on its fixed GSI and, when connected, on the PIC input its byte names. It also confirms that a fully disabled routing set lets nothing but the SCI reach the PIC, that a reserved SCI select with quiet shared lines leaves every output low, that an SCI selected onto IRQ 9 appears one cycle after its input, and that the query answer agrees with the stored byte. The directed scenarios cover what a single-cycle property cannot state. These are the reset values, read-back of stored bytes, the full SCI encoding table including the APIC-only targets, the one-cycle SCI latency against the same-cycle shared-line path, and the ignored writes to unused addresses.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned ROUTE_W       = 8;
  localparam int unsigned ROUTE_IRQ_W   = 4;
  localparam int unsigned ROUTE_DIS_BIT = 7;
  localparam logic [7:0]  ROUTE_RST     = 8'h80;
  localparam int unsigned SCI_SEL_W     = 3;
  localparam logic [2:0]  SCI_SEL_RST   = 3'd0;
  localparam int unsigned SCI_IDX_W     = 5;

  typedef logic [ROUTE_W-1:0] route_t;

  typedef struct packed {
    logic                 valid;
    logic [SCI_IDX_W-1:0] idx;
  } sci_tgt_t;

  function automatic sci_tgt_t sci_decode(input logic [SCI_SEL_W-1:0] sel);
    sci_tgt_t t;
    t.valid = 1'b1;
    unique case (sel)
      3'd0:    t.idx = 5'd9;
      3'd1:    t.idx = 5'd10;
      3'd2:    t.idx = 5'd11;
      3'd4:    t.idx = 5'd20;
      3'd5:    t.idx = 5'd21;
      default: begin t.valid = 1'b0; t.idx = '0; end
    endcase
    return t;
  endfunction

  function automatic logic route_connected(input route_t r);
    return !r[ROUTE_DIS_BIT];
  endfunction

  function automatic logic [ROUTE_IRQ_W-1:0] route_irq(input route_t r);
    return r[ROUTE_IRQ_W-1:0];
  endfunction
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = 8,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [ROUTE_W-1:0]                wdata_i,
  output logic [ROUTE_W-1:0]                rdata_o,
  output logic [NUM_PIRQ-1:0][ROUTE_W-1:0]  route_o,
  output logic [SCI_SEL_W-1:0]              sci_sel_o
);
  localparam int unsigned PIRQ_W = (NUM_PIRQ > 1) ? $clog2(NUM_PIRQ) : 1;
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(NUM_PIRQ);

  for (genvar g = 0; g < NUM_PIRQ; g++) begin : g_route
    route_t byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                byte_q <= ROUTE_RST;
      else if (we_i && addr_i == ADDR_W'(g))      byte_q <= wdata_i;
    end
    assign route_o[g] = byte_q;
  end

  logic [SCI_SEL_W-1:0] sel_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          sel_q <= SCI_SEL_RST;
    else if (we_i && addr_i == SEL_ADDR)  sel_q <= wdata_i[SCI_SEL_W-1:0];
  end
  assign sci_sel_o = sel_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i < SEL_ADDR)       rdata_o = route_o[addr_i[PIRQ_W-1:0]];
    else if (addr_i == SEL_ADDR) rdata_o = {{(ROUTE_W-SCI_SEL_W){1'b0}}, sel_q};
  end
endmodule

// File: rtl/irq_pic_mux.sv
module irq_pic_mux
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = 8,
  parameter int unsigned NUM_PIC  = 16
) (
  input  logic [NUM_PIRQ-1:0]               pirq_i,
  input  logic [NUM_PIRQ-1:0][ROUTE_W-1:0]  route_i,
  output logic [NUM_PIC-1:0]                pic_o
);
  for (genvar g = 0; g < NUM_PIC; g++) begin : g_line
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int n = 0; n < NUM_PIRQ; n++) begin
        if (pirq_i[n] && route_connected(route_i[n]) &&
            route_irq(route_i[n]) == ROUTE_IRQ_W'(g))
          hit = 1'b1;
      end
    end
    assign pic_o[g] = hit;
  end
endmodule

// File: rtl/irq_sci_steer.sv
module irq_sci_steer
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PIC = 16,
  parameter int unsigned NUM_GSI = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sci_i,
  input  logic [SCI_SEL_W-1:0] sel_i,
  output logic                 lvl_o,
  output logic [NUM_PIC-1:0]   pic_o,
  output logic [NUM_GSI-1:0]   gsi_o
);
  logic     lvl_q;
  sci_tgt_t tgt;

  // Stored level: a repeated input value leaves the register untouched.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            lvl_q <= 1'b0;
    else if (sci_i != lvl_q) lvl_q <= sci_i;
  end
  assign lvl_o = lvl_q;

  assign tgt = sci_decode(sel_i);

  for (genvar g = 0; g < NUM_GSI; g++) begin : g_gsi
    assign gsi_o[g] = lvl_q && tgt.valid && (tgt.idx == SCI_IDX_W'(g));
  end
  for (genvar g = 0; g < NUM_PIC; g++) begin : g_pic
    assign pic_o[g] = gsi_o[g];
  end
endmodule

// File: rtl/irq_route_query.sv
module irq_route_query
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = 8,
  parameter int unsigned NUM_PIC  = 16,
  parameter int unsigned GSI_W    = 5,
  parameter int unsigned PIRQ_W   = 3
) (
  input  logic [PIRQ_W-1:0]                 qry_pirq_i,
  input  logic [NUM_PIRQ-1:0][ROUTE_W-1:0]  route_i,
  output logic                              qry_pic_o,
  output logic [GSI_W-1:0]                  qry_irq_o
);
  route_t r;
  assign r = route_i[qry_pirq_i];

  always_comb begin
    if (route_connected(r)) begin
      qry_pic_o = 1'b1;
      qry_irq_o = GSI_W'(route_irq(r));
    end else begin
      qry_pic_o = 1'b0;
      qry_irq_o = GSI_W'(NUM_PIC) + GSI_W'(qry_pirq_i);
    end
  end
endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = 8,
  parameter int unsigned NUM_PIC  = 16,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned PIRQ_W   = 3,
  parameter int unsigned GSI_W    = 5,
  parameter int unsigned NUM_GSI  = NUM_PIC + NUM_PIRQ
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PIRQ-1:0]  pirq_i,
  input  logic                 sci_i,
  input  logic                 cfg_we_i,
  input  logic [ADDR_W-1:0]    cfg_addr_i,
  input  logic [ROUTE_W-1:0]   cfg_wdata_i,
  output logic [ROUTE_W-1:0]   cfg_rdata_o,
  input  logic [PIRQ_W-1:0]    qry_pirq_i,
  output logic                 qry_pic_o,
  output logic [GSI_W-1:0]     qry_irq_o,
  output logic [NUM_PIC-1:0]   pic_irq_o,
  output logic [NUM_GSI-1:0]   gsi_o
);
  logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q;
  logic [SCI_SEL_W-1:0]             sci_sel_q;
  logic                             sci_lvl_q;
  logic [NUM_PIC-1:0]               pirq_pic;
  logic [NUM_PIC-1:0]               sci_pic;
  logic [NUM_GSI-1:0]               sci_gsi;

  irq_route_regs #(.NUM_PIRQ(NUM_PIRQ), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .rdata_o  (cfg_rdata_o),
    .route_o  (route_q),
    .sci_sel_o(sci_sel_q)
  );

  irq_pic_mux #(.NUM_PIRQ(NUM_PIRQ), .NUM_PIC(NUM_PIC)) u_pic (
    .pirq_i (pirq_i),
    .route_i(route_q),
    .pic_o  (pirq_pic)
  );

  irq_sci_steer #(.NUM_PIC(NUM_PIC), .NUM_GSI(NUM_GSI)) u_sci (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sci_i (sci_i),
    .sel_i (sci_sel_q),
    .lvl_o (sci_lvl_q),
    .pic_o (sci_pic),
    .gsi_o (sci_gsi)
  );

  irq_route_query #(
    .NUM_PIRQ(NUM_PIRQ), .NUM_PIC(NUM_PIC), .GSI_W(GSI_W), .PIRQ_W(PIRQ_W)
  ) u_qry (
    .qry_pirq_i(qry_pirq_i),
    .route_i   (route_q),
    .qry_pic_o (qry_pic_o),
    .qry_irq_o (qry_irq_o)
  );

  assign pic_irq_o = pirq_pic | sci_pic;
  assign gsi_o     = {pirq_i, {NUM_PIC{1'b0}}} | sci_gsi;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = 8,
  parameter int unsigned NUM_PIC  = 16,
  parameter int unsigned PIRQ_W   = 3,
  parameter int unsigned GSI_W    = 5,
  parameter int unsigned NUM_GSI  = NUM_PIC + NUM_PIRQ
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic [NUM_PIRQ-1:0]              pirq_i,
  input logic                             sci_i,
  input logic [PIRQ_W-1:0]                qry_pirq_i,
  input logic                             qry_pic_o,
  input logic [GSI_W-1:0]                 qry_irq_o,
  input logic [NUM_PIC-1:0]               pic_irq_o,
  input logic [NUM_GSI-1:0]               gsi_o,
  input logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q,
  input logic [SCI_SEL_W-1:0]             sci_sel_q
);
  localparam logic [NUM_PIC-1:0] SCI_PIC_MASK = NUM_PIC'(32'h0E00);

  logic [NUM_PIRQ-1:0] dis_bits;
  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_dis
    assign dis_bits[n] = route_q[n][ROUTE_DIS_BIT];

    // R3
    pirq_reaches_pic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pirq_i[n] && !route_q[n][ROUTE_DIS_BIT]) |-> pic_irq_o[route_q[n][ROUTE_IRQ_W-1:0]]);
  end

  // R5
  pirq_on_gsi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pirq_i & ~gsi_o[NUM_GSI-1:NUM_PIC]) == '0);

  // R4
  all_disabled_pic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&dis_bits) |-> ((pic_irq_o & ~SCI_PIC_MASK) == '0));

  // R6
  reserved_sel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sci_sel_q inside {3'd3, 3'd6, 3'd7}) && pirq_i == '0) |-> (pic_irq_o == '0 && gsi_o == '0));

  // R8
  sci_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sci_i) && sci_sel_q == 3'd0 && $past(sci_sel_q) == 3'd0) |-> (gsi_o[9] && pic_irq_o[9]));

  // R9
  query_apic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qry_pic_o |-> (route_q[qry_pirq_i][ROUTE_DIS_BIT] &&
                    qry_irq_o == GSI_W'(NUM_PIC) + GSI_W'(qry_pirq_i)));
endmodule

bind irq_router_top irq_router_chk #(
  .NUM_PIRQ(NUM_PIRQ), .NUM_PIC(NUM_PIC), .PIRQ_W(PIRQ_W), .GSI_W(GSI_W), .NUM_GSI(NUM_GSI)
) u_chk (.*);

// File: tb/sim_irq_router_top.sv
module sim_irq_router_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  pirq_i = '0;
  logic        sci_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [7:0]  cfg_rdata_o;
  logic [2:0]  qry_pirq_i = '0;
  logic        qry_pic_o;
  logic [4:0]  qry_irq_o;
  logic [15:0] pic_irq_o;
  logic [23:0] gsi_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] sh_route [8];
  logic [2:0] sh_sel;
  logic       sh_sci;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_router_top u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int sci_target(logic [2:0] s);
    case (s)
      3'd0: return 9;
      3'd1: return 10;
      3'd2: return 11;
      3'd4: return 20;
      3'd5: return 21;
      default: return -1;
    endcase
  endfunction

  function automatic logic [15:0] exp_pic();
    logic [15:0] e = '0;
    int t = sci_target(sh_sel);
    for (int n = 0; n < 8; n++)
      if (pirq_i[n] && !sh_route[n][7]) e[sh_route[n][3:0]] = 1'b1;
    if (sh_sci && t >= 0 && t < 16) e[t] = 1'b1;
    return e;
  endfunction

  function automatic logic [23:0] exp_gsi();
    logic [23:0] e = {pirq_i, 16'h0};
    int t = sci_target(sh_sel);
    if (sh_sci && t >= 0) e[t] = 1'b1;
    return e;
  endfunction

  task automatic check_outs(string req);
    #1;
    check({req, " pic"}, 32'(pic_irq_o), 32'(exp_pic()));
    check({req, " gsi"}, 32'(gsi_o), 32'(exp_gsi()));
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (a < 4'd8) sh_route[a[2:0]] = d;
    else if (a == 4'd8) sh_sel = d[2:0];
  endtask

  task automatic rd_check(string req, logic [3:0] a, logic [7:0] exp);
    cfg_addr_i = a;
    #1;
    check(req, 32'(cfg_rdata_o), 32'(exp));
  endtask

  task automatic set_sci(logic v);
    @(negedge clk_i);
    sci_i = v;
    @(negedge clk_i);
    sh_sci = v;
  endtask

  task automatic t_reset();
    for (int n = 0; n < 8; n++) sh_route[n] = 8'h80;
    sh_sel = 3'd0; sh_sci = 1'b0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int n = 0; n < 8; n++) rd_check("R1 route reset", 4'(n), 8'h80);
    rd_check("R1 sel reset", 4'd8, 8'h00);
    check_outs("R1 idle");
    pirq_i = 8'hFF;
    check_outs("R4 default disabled");
    pirq_i = 8'h00;
  endtask

  task automatic t_cfg_rw();
    wr(4'd3, 8'h7A);
    rd_check("R2 full byte stored", 4'd3, 8'h7A);
    wr(4'd8, 8'hFD);
    rd_check("R2 sel bits 2:0 only", 4'd8, 8'h05);
    wr(4'd3, 8'h80);
  endtask

  task automatic t_pic_share();
    logic [7:0] pats [6] = '{8'h01, 8'h04, 8'h05, 8'h10, 8'h15, 8'h80};
    wr(4'd0, 8'h05);
    wr(4'd2, 8'h05);
    wr(4'd4, 8'h0C);
    wr(4'd7, 8'h00);
    foreach (pats[i]) begin
      @(negedge clk_i);
      pirq_i = pats[i];
      check_outs("R3 shared pic");
    end
    pirq_i = '0;
  endtask

  task automatic t_disable();
    wr(4'd2, 8'h85);
    @(negedge clk_i);
    pirq_i = 8'h04;
    #1;
    check("R4 disabled line off pic", 32'(pic_irq_o), 32'h0);
    check("R5 disabled line on gsi18", 32'(gsi_o[18]), 32'h1);
    pirq_i = '0;
  endtask

  task automatic t_gsi_fixed();
    logic [7:0] pats [4] = '{8'hA5, 8'h5A, 8'hFF, 8'h01};
    foreach (pats[i]) begin
      @(negedge clk_i);
      pirq_i = pats[i];
      #1;
      check("R5 gsi upper", 32'(gsi_o[23:16]), 32'(pats[i]));
      check("R5 gsi lower", 32'(gsi_o[15:0]), 32'h0);
    end
    pirq_i = '0;
  endtask

  task automatic t_sci_sel();
    set_sci(1'b1);
    for (int s = 0; s < 8; s++) begin
      wr(4'd8, 8'(s));
      check_outs((s == 3 || s > 5) ? "R6 reserved select" : "R7 sci target");
    end
    set_sci(1'b0);
    check_outs("R7 sci low");
  endtask

  task automatic t_sci_latency();
    wr(4'd8, 8'h01);
    @(negedge clk_i);
    sci_i = 1'b1;
    pirq_i = 8'h80;
    #1;
    check("R8 pirq same cycle", 32'(gsi_o[23]), 32'h1);
    check("R8 sci not yet", 32'(gsi_o[10]), 32'h0);
    @(negedge clk_i);
    sh_sci = 1'b1;
    check_outs("R8 sci after edge");
    sci_i = 1'b0;
    pirq_i = '0;
    @(negedge clk_i);
    sh_sci = 1'b0;
    check_outs("R8 sci released");
  endtask

  task automatic t_query();
    wr(4'd1, 8'h0E);
    for (int n = 0; n < 8; n++) begin
      qry_pirq_i = 3'(n);
      #1;
      if (sh_route[n][7]) begin
        check("R9 apic flag", 32'(qry_pic_o), 32'h0);
        check("R9 apic irq", 32'(qry_irq_o), 32'(16 + n));
      end else begin
        check("R9 pic flag", 32'(qry_pic_o), 32'h1);
        check("R9 pic irq", 32'(qry_irq_o), 32'(sh_route[n][3:0]));
      end
    end
  endtask

  task automatic t_ignored();
    for (int a = 9; a < 16; a++) wr(4'(a), 8'h00);
    for (int n = 0; n < 8; n++) rd_check("R10 route kept", 4'(n), sh_route[n]);
    rd_check("R10 sel kept", 4'd8, {5'b0, sh_sel});
    pirq_i = 8'h03;
    check_outs("R10 outputs kept");
    pirq_i = '0;
  endtask

  initial begin
    t_reset();
    t_cfg_rw();
    t_pic_share();
    t_disable();
    t_gsi_fixed();
    t_sci_sel();
    t_sci_latency();
    t_query();
    t_ignored();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule